// File: doc/BRIEF.md
# Reloadable LUT Constant Multiplier

The block multiplies a small unsigned operand by a constant. It does not use an arithmetic multiplier in the datapath. The product is read from small writable tables, one table per product bit. All tables are addressed by the same operand, and the lookup is purely combinational.

To change the constant, a caller presents a new value on the load interface while `ready_o` is high. A filler controller then recomputes the table contents for every operand value and writes one entry per cycle. When the last entry is written it raises `ready_o` again. The read path and its wiring stay the same for every constant; only the stored bits change. While a refill is in progress the result is flagged invalid, so a partly written table is never presented as a valid result.

Top module: `lut_const_mult`

## Requirements
- R1: After reset, `valid_o` is 0 and `ready_o` is 1. The tables hold no constant until the first load completes.
- R2: Once constant 3 is loaded, operand values 0, 1, 2 and 3 give products 0, 3, 6 and 9.
- R3: Once constant 5 is loaded, operand values 0, 1, 2 and 3 give products 0, 5, 10 and 15.
- R4: The product is (operand × K) mod 16, with the constant given as 4 unsigned bits on `load_k_i`. For example, K=7 with operand 3 gives 5, and K=15 gives 0, 15, 14, 13.
- R5: A load is accepted on a clock edge where `load_req_i` and `ready_o` are both high. `ready_o` is then low for exactly 4 cycles, one per operand value, and is high again in the 5th cycle.
- R6: `valid_o` falls in the cycle after a load is accepted and stays low until `ready_o` returns. It rises together with `ready_o`, and `valid_o` is never high while `ready_o` is low.
- R7: A load request made while `ready_o` is low is ignored. It neither changes the constant being written nor lengthens the refill.
- R8: Whenever `valid_o` is high, operand 0 gives product 0.
- R9: The product follows `operand_i` within the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| operand_i | input | 2 | Operand that addresses the tables |
| product_o | output | 4 | Product read from the bit tables |
| valid_o | output | 1 | Tables hold a complete constant |
| load_req_i | input | 1 | Request to load a new constant |
| load_k_i | input | 4 | New constant value |
| ready_o | output | 1 | Filler idle; a load can be accepted |

## Verification
The bound checker tests on every cycle that:
- an accepted load drops `ready_o` and `valid_o`;
- a refill lasts exactly as many cycles as there are operand values;
- `valid_o` only rises together with `ready_o` and is never high while the filler is busy;
- operand 0 reads as zero whenever the result is valid.

The arithmetic content of the tables can only be shown by the bench's scenarios: sweeps after loading 3, 5, 7 and 15. The same holds for truncation, for a request made during a refill leaving the old constant in force, and for the combinational path from operand to product.

// File: rtl/lcm_pkg.sv
package lcm_pkg;
  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_RUN  = 1'b1
  } fill_state_e;
endpackage

// File: rtl/lcm_bit_table.sv
module lcm_bit_table #(
  parameter int unsigned AW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic          wbit_i,
  input  logic [AW-1:0] raddr_i,
  output logic          rbit_o
);
  localparam int unsigned DEPTH = 2 ** AW;

  logic [DEPTH-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wbit_i;
    end
  end

  assign rbit_o = mem_q[raddr_i];
endmodule

// File: rtl/lcm_filler.sv
module lcm_filler
  import lcm_pkg::*;
#(
  parameter int unsigned OPW = 2,
  parameter int unsigned PW  = 4,
  parameter int unsigned KW  = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [KW-1:0]  k_i,
  output logic           busy_o,
  output logic           accept_o,
  output logic           we_o,
  output logic [OPW-1:0] waddr_o,
  output logic [PW-1:0]  wdata_o,
  output logic           done_o
);
  localparam logic [OPW-1:0] LAST_IDX = {OPW{1'b1}};

  fill_state_e    state_q;
  logic [OPW-1:0] idx_q;
  logic [PW-1:0]  acc_q;
  logic [PW-1:0]  step_q;

  assign busy_o   = (state_q == FILL_RUN);
  assign accept_o = start_i && !busy_o;
  assign we_o     = busy_o;
  assign waddr_o  = idx_q;
  assign wdata_o  = acc_q;
  assign done_o   = busy_o && (idx_q == LAST_IDX);

  // Running sum: entry i holds i*K, built by repeated addition of K.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FILL_IDLE;
      idx_q   <= '0;
      acc_q   <= '0;
      step_q  <= '0;
    end else if (accept_o) begin
      state_q <= FILL_RUN;
      idx_q   <= '0;
      acc_q   <= '0;
      step_q  <= PW'(k_i);
    end else if (busy_o) begin
      idx_q <= idx_q + 1'b1;
      acc_q <= acc_q + step_q;
      if (done_o) state_q <= FILL_IDLE;
    end
  end
endmodule

// File: rtl/lut_const_mult.sv
module lut_const_mult #(
  parameter int unsigned OPW = 2,
  parameter int unsigned PW  = 4,
  parameter int unsigned KW  = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [OPW-1:0] operand_i,
  output logic [PW-1:0]  product_o,
  output logic           valid_o,
  input  logic           load_req_i,
  input  logic [KW-1:0]  load_k_i,
  output logic           ready_o
);
  logic           busy;
  logic           accept;
  logic           we;
  logic [OPW-1:0] waddr;
  logic [PW-1:0]  wdata;
  logic           done;
  logic           valid_q;

  lcm_filler #(.OPW(OPW), .PW(PW), .KW(KW)) u_filler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (load_req_i),
    .k_i      (load_k_i),
    .busy_o   (busy),
    .accept_o (accept),
    .we_o     (we),
    .waddr_o  (waddr),
    .wdata_o  (wdata),
    .done_o   (done)
  );

  for (genvar b = 0; b < PW; b++) begin : g_bit
    lcm_bit_table #(.AW(OPW)) u_tbl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we),
      .waddr_i (waddr),
      .wbit_i  (wdata[b]),
      .raddr_i (operand_i),
      .rbit_o  (product_o[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     valid_q <= 1'b0;
    else if (accept) valid_q <= 1'b0;
    else if (done)   valid_q <= 1'b1;
  end

  assign valid_o = valid_q;
  assign ready_o = !busy;
endmodule

// File: rtl/lut_const_mult_chk.sv
module lut_const_mult_chk #(
  parameter int unsigned OPW = 2,
  parameter int unsigned PW  = 4,
  parameter int unsigned KW  = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [OPW-1:0] operand_i,
  input logic [PW-1:0]  product_o,
  input logic           valid_o,
  input logic           load_req_i,
  input logic           ready_o
);
  localparam int unsigned DEPTH = 2 ** OPW;
  localparam int unsigned CW    = OPW + 2;

  logic [CW-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      low_cnt_q <= '0;
    else if (!ready_o) low_cnt_q <= low_cnt_q + 1'b1;
    else               low_cnt_q <= '0;
  end

  p_accept_drops_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_req_i && ready_o) |=> !ready_o);

  p_fill_length_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (low_cnt_q == CW'(DEPTH)));

  p_accept_drops_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_req_i && ready_o) |=> !valid_o);

  p_no_valid_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ready_o);

  p_valid_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $rose(ready_o));

  p_zero_operand_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && operand_i == '0) |-> (product_o == '0));
endmodule

bind lut_const_mult lut_const_mult_chk #(.OPW(OPW), .PW(PW), .KW(KW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .operand_i  (operand_i),
  .product_o  (product_o),
  .valid_o    (valid_o),
  .load_req_i (load_req_i),
  .ready_o    (ready_o)
);

// File: tb/lut_const_mult_test.sv
`timescale 1ns/1ps
module lut_const_mult_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] operand = '0;
  logic [3:0] product;
  logic       valid;
  logic       load_req = 1'b0;
  logic [3:0] load_k = '0;
  logic       ready;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int cycles = 0;

  always #2 clk = ~clk;

  lut_const_mult uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .operand_i  (operand),
    .product_o  (product),
    .valid_o    (valid),
    .load_req_i (load_req),
    .load_k_i   (load_k),
    .ready_o    (ready)
  );

  // Behavioural reference model
  int m_left;
  int m_k;
  int m_pend;
  bit m_valid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left  <= 0;
      m_k     <= 0;
      m_pend  <= 0;
      m_valid <= 1'b0;
    end else if (m_left == 0 && load_req) begin
      m_left  <= 4;
      m_pend  <= int'(load_k);
      m_valid <= 1'b0;
    end else if (m_left > 0) begin
      m_left <= m_left - 1;
      if (m_left == 1) begin
        m_valid <= 1'b1;
        m_k     <= m_pend;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(ready == (m_left == 0), "R5 ready vs model", int'(ready), int'(m_left == 0));
      chk(valid == m_valid, "R6 valid vs model", int'(valid), int'(m_valid));
      if (m_valid)
        chk(int'(product) == ((int'(operand) * m_k) & 15), "R4 product vs model",
            int'(product), (int'(operand) * m_k) & 15);
    end
  end

  task automatic load(input int k);
    @(posedge clk); #1;
    load_req = 1'b1;
    load_k   = 4'(k);
    @(posedge clk); #1;
    load_req = 1'b0;
  endtask

  task automatic sweep(input int k, input string req);
    for (int a = 0; a < 4; a++) begin
      @(posedge clk); #1;
      operand = 2'(a);
      #0.5;
      chk(int'(product) == ((a * k) & 15), req, int'(product), (a * k) & 15);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #9;
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid == 1'b0, "R1 valid after reset", int'(valid), 0);
    chk(ready == 1'b1, "R1 ready after reset", int'(ready), 1);

    // R5 R6: timing of a refill with constant 3
    load(3);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(ready == 1'b0, "R5 ready low during fill", int'(ready), 0);
      chk(valid == 1'b0, "R6 valid low during fill", int'(valid), 0);
    end
    @(negedge clk);
    chk(ready == 1'b1, "R5 ready back after 4 cycles", int'(ready), 1);
    chk(valid == 1'b1, "R6 valid after fill", int'(valid), 1);
    sweep(3, "R2 constant 3");

    // R9: same-cycle change of product with operand
    @(posedge clk); #1;
    operand = 2'd1;
    #0.2;
    chk(product == 4'd3, "R9 combinational read", int'(product), 3);
    operand = 2'd3;
    #0.2;
    chk(product == 4'd9, "R9 combinational read", int'(product), 9);

    load(5);
    repeat (5) @(posedge clk);
    sweep(5, "R3 constant 5");

    // R7: request during a refill is ignored
    load(3);
    load_req = 1'b1;
    load_k   = 4'd1;
    @(posedge clk); #1;
    load_req = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(ready == 1'b0, "R7 fill not restarted", int'(ready), 0);
    @(negedge clk);
    chk(ready == 1'b1, "R7 fill length unchanged", int'(ready), 1);
    operand = 2'd3;
    #0.5;
    chk(product == 4'd9, "R7 ignored constant", int'(product), 9);

    load(7);
    repeat (5) @(posedge clk);
    sweep(7, "R4 truncation K=7");
    load(15);
    repeat (5) @(posedge clk);
    sweep(15, "R4 truncation K=15");
    @(posedge clk); #1;
    operand = 2'd0;
    #0.5;
    chk(product == 4'd0, "R8 zero operand", int'(product), 0);

    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule